// File: doc/BRIEF.md
# I2C Master Baud and SCL Phase Timer

This block turns a core clock into the timing grid an I2C master needs. A 7-bit baud value holds two fields: a 3-bit exponent N and a 4-bit linear factor M. A first stage divides the core clock by 2^(N+1). A second stage divides that result by M+1 to form a sample tick. Ten sample ticks make one SCL period. The first five ticks form the low phase and the last five form the high phase. A single-cycle enable marks each of four points: the start of the low phase, the data-change point, the start of the high phase and the sample point. The surrounding bus engine uses these enables to move SDA and to sample it.

The phase sequencer is a three-state machine. PH_IDLE goes to PH_LOW when `run` rises. PH_LOW goes to PH_HIGH on the fifth tick. PH_HIGH goes back to PH_LOW on the tenth tick, which is the period boundary. PH_LOW and PH_HIGH both return to PH_IDLE as soon as `run` falls. A baud write is first held as pending. It is copied into the active setting either at the next period boundary or, if the sequencer is idle, on the next clock edge.

A separate helper searches all 128 settings for the one whose SCL rate lies closest to a requested rate. Its machine goes from SR_IDLE to SR_SCAN on `fit_go`. It stays in SR_SCAN for one cycle per candidate, then passes through SR_DONE for one cycle and returns to SR_IDLE.

Top module: `i2c_baud_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `scl_out` is 1, `sample_tick`, `low_start`, `high_start`, `change_en`, `sample_en`, `fit_busy` and `fit_done` are 0, and `fit_best` is 0.
- R2: While running, `sample_tick` pulses once every D = (M+1)*2^(N+1) core cycles. M is taken from `baud_in[6:3]` and N from `baud_in[2:0]`.
- R3: One SCL period lasts ten sample ticks, which is 10*D core cycles. `scl_out` is 0 for the first 5*D cycles and 1 for the last 5*D cycles.
- R4: In each period, `low_start` pulses in the first cycle of the low phase. Measured from that pulse, `change_en` pulses 2*D cycles later, `high_start` 5*D cycles later and `sample_en` 7*D cycles later. Each is one cycle wide and occurs once per period.
- R5: While `run` is 0, `scl_out` stays 1 and none of the tick or phase pulses occur. When `run` rises, `scl_out` goes low and `low_start` pulses on the next clock edge. When `run` falls, `scl_out` returns to 1 on the next edge.
- R6: A baud write made while the low or high phase is active leaves the current period at its old length. The new setting takes effect from the next period boundary.
- R7: A baud write made while idle takes effect on the next edge, so the first period after `run` rises already uses it.
- R8: `fit_go` starts a search over every setting. N is scanned in the outer loop and M in the inner loop, both in ascending order. Each rate is floor(CORE_HZ / (10*(M+1)*2^(N+1))). The search keeps the setting with the smallest absolute difference from `fit_target`, and replaces it only on a strictly smaller difference. The starting best difference is CORE_HZ and the starting code is 0. The result on `fit_best` uses the baud layout, with M in bits 6:3 and N in bits 2:0.
- R9: After `fit_go`, `fit_busy` is high for exactly 128 cycles, and then `fit_done` pulses for one cycle. A `fit_go` issued while busy is ignored, and the target latched at the start is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables the SCL timing sequence |
| baud_wr | input | 1 | Strobe that captures `baud_in` as the pending setting |
| baud_in | input | 7 | M in bits 6:3, N in bits 2:0 |
| scl_out | output | 1 | SCL level, 1 when idle |
| sample_tick | output | 1 | Sample-rate tick, ten per SCL period |
| low_start | output | 1 | First cycle of the low phase |
| high_start | output | 1 | First cycle of the high phase |
| change_en | output | 1 | Data-change point inside the low phase |
| sample_en | output | 1 | Sample point inside the high phase |
| fit_go | input | 1 | Starts the best-fit search |
| fit_target | input | 26 | Requested SCL rate in Hz |
| fit_busy | output | 1 | Search in progress |
| fit_done | output | 1 | One-cycle pulse when the search ends |
| fit_best | output | 7 | Best setting found, in baud layout |

## Verification
The assertions assume that reset is held for at least one edge before any stimulus. They also assume that `baud_in` only reaches the active setting through the pending register, so the counters are at zero whenever the divisors change. The bench respects this: every input is driven on the falling edge, `baud_wr` is a single-cycle strobe, and `fit_go` is a single-cycle strobe. Baud writes are placed both in the middle of an active period and while idle, so both update paths are covered. Search targets cover an exact tie, a rate above the fastest setting, a zero target and common bus rates, and the expected codes are computed from the rate formula.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;

    localparam int TICKS_PER_SCL = 10;
    localparam int TIDX_W        = 4;

    typedef logic [TIDX_W-1:0] tidx_t;

    localparam tidx_t IDX_HIGH   = tidx_t'(TICKS_PER_SCL / 2);
    localparam tidx_t IDX_LOWEND = tidx_t'(TICKS_PER_SCL / 2 - 1);
    localparam tidx_t IDX_LAST   = tidx_t'(TICKS_PER_SCL - 1);
    localparam tidx_t IDX_CHG    = tidx_t'(TICKS_PER_SCL / 5);
    localparam tidx_t IDX_SMP    = tidx_t'(TICKS_PER_SCL / 2 + TICKS_PER_SCL / 5);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_SCAN,
        SR_DONE
    } srch_e;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int NW = 3,
    localparam int PCW = 1 << NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] n_exp,
    output logic          pre_tick
);

    logic [PCW-1:0] pcnt;
    logic [PCW-1:0] lim;
    logic [NW:0]    sh;

    always_comb begin
        sh       = {1'b0, n_exp} + 1'b1;
        lim      = ~({PCW{1'b1}} << sh);
        pre_tick = en && (pcnt == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en || pre_tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pcnt <= lim));

endmodule

// File: rtl/baud_linear_div.sv
module baud_linear_div #(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pre_tick,
    input  logic [MW-1:0] m_lin,
    output logic          tick
);

    logic [MW-1:0] lcnt;

    assign tick = pre_tick && (lcnt == m_lin);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lcnt <= '0;
        end else if (pre_tick) begin
            lcnt <= tick ? '0 : lcnt + 1'b1;
        end
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import i2c_baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic cnt_en,
    output logic idle,
    output logic wrap,
    output logic scl_out,
    output logic low_start,
    output logic high_start,
    output logic change_en,
    output logic sample_en
);

    phase_e state, state_nx;
    tidx_t  idx, idx_nx;
    logic   adv, adv_nx;

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        adv_nx   = 1'b0;
        wrap     = 1'b0;
        unique case (state)
            PH_IDLE: begin
                idx_nx = '0;
                if (run) begin
                    state_nx = PH_LOW;
                    adv_nx   = 1'b1;
                end
            end
            PH_LOW: begin
                if (!run) begin
                    state_nx = PH_IDLE;
                    idx_nx   = '0;
                end else if (tick) begin
                    adv_nx = 1'b1;
                    idx_nx = idx + 1'b1;
                    if (idx == IDX_LOWEND) state_nx = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (!run) begin
                    state_nx = PH_IDLE;
                    idx_nx   = '0;
                end else if (tick) begin
                    adv_nx = 1'b1;
                    if (idx == IDX_LAST) begin
                        state_nx = PH_LOW;
                        idx_nx   = '0;
                        wrap     = 1'b1;
                    end else begin
                        idx_nx = idx + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = PH_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            idx   <= '0;
            adv   <= 1'b0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            adv   <= adv_nx;
        end
    end

    always_comb begin
        idle       = (state == PH_IDLE);
        cnt_en     = !idle && run;
        scl_out    = (state != PH_LOW);
        low_start  = adv && (state == PH_LOW)  && (idx == '0);
        change_en  = adv && (state == PH_LOW)  && (idx == IDX_CHG);
        high_start = adv && (state == PH_HIGH) && (idx == IDX_HIGH);
        sample_en  = adv && (state == PH_HIGH) && (idx == IDX_SMP);
    end

    assert_wrap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> low_start);

    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !tick) |=> $stable(idx));

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> scl_out);

    assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start, change_en, sample_en}));

endmodule

// File: rtl/baud_fit_search.sv
module baud_fit_search
    import i2c_baud_pkg::*;
#(
    parameter int unsigned CORE_HZ = 50_000_000,
    parameter int MW = 4,
    parameter int NW = 3,
    localparam int CW = MW + NW,
    localparam int NM = 1 << MW,
    localparam int RW = $clog2(CORE_HZ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [RW-1:0] target,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] best
);

    srch_e state, state_nx;

    logic [RW-1:0] base_rate [NM];
    logic [CW-1:0] cand;
    logic [RW-1:0] tgt_q;
    logic [RW-1:0] best_diff;
    logic [RW-1:0] rate;
    logic [RW-1:0] diff;
    logic [MW-1:0] m_c;
    logic [NW-1:0] n_c;
    logic [NW:0]   sh;
    logic          better;

    for (genvar g = 0; g < NM; g++) begin : g_base
        localparam int unsigned Q = CORE_HZ / (10 * (g + 1));
        assign base_rate[g] = RW'(Q);
    end

    always_comb begin
        n_c    = cand[CW-1 -: NW];
        m_c    = cand[MW-1:0];
        sh     = {1'b0, n_c} + 1'b1;
        rate   = base_rate[m_c] >> sh;
        diff   = (tgt_q >= rate) ? (tgt_q - rate) : (rate - tgt_q);
        better = diff < best_diff;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SR_IDLE: if (go) state_nx = SR_SCAN;
            SR_SCAN: if (cand == '1) state_nx = SR_DONE;
            SR_DONE: state_nx = SR_IDLE;
            default: state_nx = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SR_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand      <= '0;
            tgt_q     <= '0;
            best      <= '0;
            best_diff <= RW'(CORE_HZ);
        end else if (state == SR_IDLE && go) begin
            cand      <= '0;
            tgt_q     <= target;
            best      <= '0;
            best_diff <= RW'(CORE_HZ);
        end else if (state == SR_SCAN) begin
            cand <= cand + 1'b1;
            if (better) begin
                best      <= {m_c, n_c};
                best_diff <= diff;
            end
        end
    end

    always_comb begin
        busy = (state == SR_SCAN);
        done = (state == SR_DONE);
    end

    assert_scan_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cand != '1) |=> busy);

    assert_scan_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cand == '1) |=> (done && !busy));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_best_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SR_IDLE && !go) |=> $stable(best));

endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen
    import i2c_baud_pkg::*;
#(
    parameter int unsigned CORE_HZ = 50_000_000,
    parameter int MW = 4,
    parameter int NW = 3,
    localparam int BW = MW + NW,
    localparam int RW = $clog2(CORE_HZ + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          baud_wr,
    input  logic [BW-1:0] baud_in,
    output logic          scl_out,
    output logic          sample_tick,
    output logic          low_start,
    output logic          high_start,
    output logic          change_en,
    output logic          sample_en,
    input  logic          fit_go,
    input  logic [RW-1:0] fit_target,
    output logic          fit_busy,
    output logic          fit_done,
    output logic [BW-1:0] fit_best
);

    logic [BW-1:0] baud_act;
    logic [BW-1:0] baud_pend;
    logic          pend_vld;
    logic          apply;
    logic          cnt_en;
    logic          idle;
    logic          wrap;
    logic          pre_tick;

    assign apply = pend_vld && (idle || wrap);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_act  <= '0;
            baud_pend <= '0;
            pend_vld  <= 1'b0;
        end else begin
            if (apply)   baud_act  <= baud_pend;
            if (baud_wr) baud_pend <= baud_in;
            pend_vld <= baud_wr || (pend_vld && !apply);
        end
    end

    baud_prescaler #(.NW(NW)) i_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .n_exp    (baud_act[NW-1:0]),
        .pre_tick (pre_tick)
    );

    baud_linear_div #(.MW(MW)) i_lindiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .pre_tick (pre_tick),
        .m_lin    (baud_act[BW-1:NW]),
        .tick     (sample_tick)
    );

    scl_phase_fsm i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (sample_tick),
        .cnt_en     (cnt_en),
        .idle       (idle),
        .wrap       (wrap),
        .scl_out    (scl_out),
        .low_start  (low_start),
        .high_start (high_start),
        .change_en  (change_en),
        .sample_en  (sample_en)
    );

    baud_fit_search #(.CORE_HZ(CORE_HZ), .MW(MW), .NW(NW)) i_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (fit_go),
        .target (fit_target),
        .busy   (fit_busy),
        .done   (fit_done),
        .best   (fit_best)
    );

    assert_baud_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle || wrap) |=> $stable(baud_act));

    assert_baud_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pend_vld) |=> (baud_act == $past(baud_pend)));

endmodule

// File: tb/test_i2c_baud_gen.sv
module test_i2c_baud_gen;

    localparam int    CLK_PERIOD = 10;
    localparam longint CORE = 50_000_000;
    localparam int    RW = $clog2(CORE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          baud_wr = 1'b0;
    logic [6:0]    baud_in = '0;
    logic          scl_out, sample_tick, low_start, high_start, change_en, sample_en;
    logic          fit_go = 1'b0;
    logic [RW-1:0] fit_target = '0;
    logic          fit_busy, fit_done;
    logic [6:0]    fit_best;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_baud_gen i_i2c_baud_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .baud_wr(baud_wr), .baud_in(baud_in),
        .scl_out(scl_out), .sample_tick(sample_tick), .low_start(low_start),
        .high_start(high_start), .change_en(change_en), .sample_en(sample_en),
        .fit_go(fit_go), .fit_target(fit_target), .fit_busy(fit_busy),
        .fit_done(fit_done), .fit_best(fit_best)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [6:0] model_best(input longint target);
        longint best_diff = CORE;
        logic [6:0] code = '0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                longint rate = CORE / (10 * (m + 1) * (longint'(1) << (n + 1)));
                longint diff = (target >= rate) ? target - rate : rate - target;
                if (diff < best_diff) begin
                    best_diff = diff;
                    code = {m[3:0], n[2:0]};
                end
            end
        end
        return code;
    endfunction

    task automatic write_baud(input int m, input int n);
        @(negedge clk);
        baud_wr = 1'b1;
        baud_in = {m[3:0], n[2:0]};
        @(negedge clk);
        baud_wr = 1'b0;
    endtask

    task automatic wait_low_start(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (low_start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(output int per, output int lowc, output int ticks,
                           output int ochg, output int ohi, output int osmp,
                           output int npulse);
        bit seen;
        int t;
        wait_low_start(seen);
        chk(seen, "R4 low_start seen", seen, 1);
        t = 0; ticks = 0; ochg = -1; ohi = -1; osmp = -1; npulse = 0;
        lowc = (scl_out == 1'b0) ? 1 : 0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            t++;
            if (low_start) break;
            if (sample_tick) ticks++;
            if (change_en)  begin ochg = t; npulse++; end
            if (high_start) begin ohi  = t; npulse++; end
            if (sample_en)  begin osmp = t; npulse++; end
            if (!scl_out) lowc++;
        end
        per = t;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(scl_out == 1'b1, "R1 scl in reset", scl_out, 1);
        chk({sample_tick, low_start, high_start, change_en, sample_en} == '0,
            "R1 pulses in reset", {sample_tick, low_start, high_start, change_en, sample_en}, 0);
        chk({fit_busy, fit_done} == '0, "R1 search flags in reset", {fit_busy, fit_done}, 0);
        chk(fit_best == '0, "R1 fit_best in reset", fit_best, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b1 && !low_start, "R1 state after reset", scl_out, 1);
    endtask

    task automatic t_period(input int m, input int n);
        int per, lowc, ticks, ochg, ohi, osmp, np;
        int d = (m + 1) * (1 << (n + 1));
        @(negedge clk);
        run = 1'b0;
        write_baud(m, n);
        @(negedge clk);
        run = 1'b1;
        measure(per, lowc, ticks, ochg, ohi, osmp, np);
        chk(per == 10 * d, "R7 first period after idle write", per, 10 * d);
        chk(per == 10 * d, "R3 period length", per, 10 * d);
        chk(lowc == 5 * d, "R3 low phase length", lowc, 5 * d);
        chk(ticks == 10, "R2 ticks per period", ticks, 10);
        chk(ochg == 2 * d, "R4 change point offset", ochg, 2 * d);
        chk(ohi == 5 * d, "R4 high start offset", ohi, 5 * d);
        chk(osmp == 7 * d, "R4 sample point offset", osmp, 7 * d);
        chk(np == 3, "R4 one pulse each", np, 3);
    endtask

    task automatic t_tick_spacing(input int m, input int n);
        int d = (m + 1) * (1 << (n + 1));
        int last = -1, gap = -1, errs = 0, cyc = 0;
        for (int i = 0; i < 12 * d; i++) begin
            @(negedge clk);
            cyc++;
            if (sample_tick) begin
                if (last >= 0) begin
                    gap = cyc - last;
                    if (gap != d) errs++;
                end
                last = cyc;
            end
        end
        chk(errs == 0 && gap == d, "R2 tick spacing", gap, d);
    endtask

    task automatic t_idle();
        int errs = 0;
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1, "R5 scl high after run falls", scl_out, 1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!scl_out || sample_tick || low_start || high_start || change_en || sample_en)
                errs++;
        end
        chk(errs == 0, "R5 quiet while idle", errs, 0);
        run = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b0 && low_start == 1'b1, "R5 start one edge after run",
            {scl_out, low_start}, 1);
    endtask

    task automatic t_update_active(input int ma, input int na, input int mb, input int nb);
        bit seen;
        int per, lowc, ticks, ochg, ohi, osmp, np, t;
        int da = (ma + 1) * (1 << (na + 1));
        int db = (mb + 1) * (1 << (nb + 1));
        t_period(ma, na);
        wait_low_start(seen);
        repeat (5) @(negedge clk);
        baud_wr = 1'b1;
        baud_in = {mb[3:0], nb[2:0]};
        @(negedge clk);
        baud_wr = 1'b0;
        t = 7;
        for (int i = 0; i < 30000; i++) begin
            if (low_start) break;
            @(negedge clk);
            t++;
        end
        t--;
        chk(t == 10 * da, "R6 current period keeps old setting", t, 10 * da);
        measure(per, lowc, ticks, ochg, ohi, osmp, np);
        chk(per == 10 * db, "R6 next period uses new setting", per, 10 * db);
    endtask

    task automatic t_search(input longint target, input string tag);
        logic [6:0] exp_code = model_best(target);
        int busyc = 0, donec = 0;
        @(negedge clk);
        fit_go = 1'b1;
        fit_target = RW'(target);
        @(negedge clk);
        fit_go = 1'b0;
        chk(fit_busy == 1'b1, "R9 busy right after go", fit_busy, 1);
        for (int i = 0; i < 400; i++) begin
            if (fit_busy) busyc++;
            if (fit_done) begin donec++; break; end
            @(negedge clk);
        end
        @(negedge clk);
        if (fit_done) donec++;
        chk(busyc == 128, "R9 busy cycle count", busyc, 128);
        chk(donec == 1, "R9 single done pulse", donec, 1);
        chk(fit_best == exp_code, tag, fit_best, exp_code);
    endtask

    task automatic t_search_ignore();
        logic [6:0] exp_code = model_best(100_000);
        @(negedge clk);
        fit_go = 1'b1;
        fit_target = RW'(100_000);
        @(negedge clk);
        fit_go = 1'b0;
        repeat (20) @(negedge clk);
        fit_go = 1'b1;
        fit_target = RW'(2_000_000);
        @(negedge clk);
        fit_go = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (fit_done) break;
            @(negedge clk);
        end
        chk(fit_best == exp_code, "R9 go while busy ignored", fit_best, exp_code);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_period(0, 0);
        t_period(2, 1);
        t_period(15, 0);
        t_period(0, 7);
        t_tick_spacing(0, 7);
        t_period(5, 2);
        t_tick_spacing(5, 2);
        t_idle();
        t_update_active(2, 1, 1, 2);
        t_update_active(3, 0, 0, 0);
        run = 1'b0;
        t_search(100_000, "R8 best fit for 100 kHz");
        t_search(400_000, "R8 best fit for 400 kHz");
        t_search(0, "R8 best fit for zero target");
        t_search(3_000_000, "R8 target above fastest rate");
        t_search(625_000, "R8 tie keeps first visited");
        chk(fit_best == 7'd24, "R8 tie code M3 N0", fit_best, 24);
        t_search_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule